// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block pulls instructions for a small 32-bit instruction set out of a byte-wide read port, one byte per clock. The opcode byte is taken first; its upper nibble (the instruction class) alone fixes how many further bytes belong to the instruction, whether a register-specifier byte is present, and where a little-endian constant begins. When the last byte has arrived, the unit presents the decoded fields, the instruction length and the address of the following instruction on a valid/ready output. It advances only after the consumer accepts.

The unit also keeps a two-bit machine status. A halt instruction, an illegal encoding or an address error reported by the memory port each end fetching. Once fetching has ended, the status holds until a synchronous reset. Register reads, execution and data memory belong to other blocks.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0, `stat` is 0 (running), and a read is requested at address `START_PC` (default 0).
- R2: Reads occur one per cycle at consecutive addresses starting at the instruction's first byte. The number of reads equals the instruction length taken from the class nibble (bits 7:4 of the first byte): classes 0, 1 and 9 take 1 byte; classes 2, 6, A and B take 2 bytes; classes 7 and 8 take 5 bytes; classes 3, 4 and 5 take 6 bytes.
- R3: `icode` is bits 7:4 of the first byte and `ifun` is bits 3:0. For classes 2, 3, 4, 5, 6, A and B, `ra` is bits 7:4 of the second byte and `rb` is bits 3:0 of it. For all other classes both read 0xF.
- R4: The 32-bit constant is assembled least significant byte first. It starts at byte offset 1 for classes 7 and 8 and at byte offset 2 for classes 3, 4 and 5. For every other class it reads 0.
- R5: `next_pc` equals the instruction's start address plus `ilen`. After a running instruction is accepted, the next read is at that address on the following cycle.
- R6: While `out_valid` is high and `out_ready` is low, all output fields stay unchanged and no read is requested.
- R7: A first byte of 0x00 (halt) is presented with `stat` = 1, and no read follows it.
- R8: An illegal first byte sets `stat` to 3 with no output and no further reads. A first byte is illegal when its class is above 0xB, when `ifun` is above 3 for class 6, when `ifun` is above 6 for classes 2 and 7, or when `ifun` is not 0 for any other class.
- R9: If `mem_err` is high on any byte of an instruction, `stat` becomes 2, the partial instruction is never presented, and reads stop.
- R10: A status other than 0 stays unchanged until reset, and reset returns the unit to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Byte read request this cycle |
| mem_addr | output | 32 | Byte address of the read |
| mem_data | input | 8 | Byte returned in the same cycle |
| mem_err | input | 1 | Address error for the byte read this cycle |
| out_valid | output | 1 | Decoded instruction available |
| out_ready | input | 1 | Consumer accepts the instruction |
| icode | output | 4 | Instruction class |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 0xF if none |
| rb | output | 4 | Second register specifier, 0xF if none |
| valc | output | 32 | Assembled constant |
| ilen | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | Address of the following instruction |
| stat | output | 2 | Status: 0 running, 1 halted, 2 address error, 3 illegal instruction |

## Verification
The main walk fetches one instruction from every class. Class 2 and class 7 each appear with a non-zero function code. This separates the four lengths, shows whether the register byte is present, and distinguishes the two constant start offsets. Constants with distinct bytes, including one with all upper bits set, would expose a byte-order or lane mix-up. Illegal first bytes are tried one per rule (high class, op code 4, jump code 7, non-zero code on nop and on move). Address errors are injected on the opcode byte and partway through a constant, so a discarded partial instruction can be told apart from a late error.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_ADDR = 2'd2,
      ST_ILL  = 2'd3
   } fstat_t;

   localparam logic [3:0] CL_HALT  = 4'h0;
   localparam logic [3:0] CL_NOP   = 4'h1;
   localparam logic [3:0] CL_MOVRR = 4'h2;
   localparam logic [3:0] CL_MOVIR = 4'h3;
   localparam logic [3:0] CL_MOVRM = 4'h4;
   localparam logic [3:0] CL_MOVMR = 4'h5;
   localparam logic [3:0] CL_ALU   = 4'h6;
   localparam logic [3:0] CL_JUMP  = 4'h7;
   localparam logic [3:0] CL_CALL  = 4'h8;
   localparam logic [3:0] CL_RET   = 4'h9;
   localparam logic [3:0] CL_PUSH  = 4'hA;
   localparam logic [3:0] CL_POP   = 4'hB;

   localparam logic [3:0] NO_REG   = 4'hF;

   // where the constant starts inside an instruction
   typedef enum logic [1:0] {
      CP_NONE = 2'd0,
      CP_AT1  = 2'd1,
      CP_AT2  = 2'd2
   } cpos_t;

endpackage

// File: rtl/ifetch_len_decode.sv
module ifetch_len_decode
   import ifetch_pkg::*;
#(
   parameter int CONST_BYTES = 4,
   parameter int LEN_W       = 3
) (
   input  logic [7:0]       first_byte,
   output logic [LEN_W-1:0] len,
   output logic             has_regs,
   output cpos_t            cpos,
   output logic             legal,
   output logic             is_halt
);

   localparam logic [LEN_W-1:0] L_ONE   = LEN_W'(1);
   localparam logic [LEN_W-1:0] L_TWO   = LEN_W'(2);
   localparam logic [LEN_W-1:0] L_BRNCH = LEN_W'(1 + CONST_BYTES);
   localparam logic [LEN_W-1:0] L_MEM   = LEN_W'(2 + CONST_BYTES);

   logic [3:0] cls;
   logic [3:0] fn;

   assign cls = first_byte[7:4];
   assign fn  = first_byte[3:0];

   always_comb begin
      len      = L_ONE;
      has_regs = 1'b0;
      cpos     = CP_NONE;
      legal    = (fn == 4'h0);
      unique case (cls)
         CL_HALT, CL_NOP, CL_RET: len = L_ONE;
         CL_MOVRR: begin
            len      = L_TWO;
            has_regs = 1'b1;
            legal    = (fn <= 4'd6);
         end
         CL_ALU: begin
            len      = L_TWO;
            has_regs = 1'b1;
            legal    = (fn <= 4'd3);
         end
         CL_PUSH, CL_POP: begin
            len      = L_TWO;
            has_regs = 1'b1;
         end
         CL_JUMP: begin
            len   = L_BRNCH;
            cpos  = CP_AT1;
            legal = (fn <= 4'd6);
         end
         CL_CALL: begin
            len  = L_BRNCH;
            cpos = CP_AT1;
         end
         CL_MOVIR, CL_MOVRM, CL_MOVMR: begin
            len      = L_MEM;
            has_regs = 1'b1;
            cpos     = CP_AT2;
         end
         default: legal = 1'b0;
      endcase
   end

   assign is_halt = (first_byte == 8'h00);

endmodule

// File: rtl/ifetch_gather.sv
module ifetch_gather
   import ifetch_pkg::*;
#(
   parameter int CONST_BYTES = 4,
   parameter int LEN_W       = 3,
   localparam int WORD_W     = 8 * CONST_BYTES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              take,
   input  logic [LEN_W-1:0]  idx,
   input  logic [7:0]        data,
   input  logic              has_regs,
   input  cpos_t             cpos,
   output logic [3:0]        ra,
   output logic [3:0]        rb,
   output logic [WORD_W-1:0] valc
);

   always_ff @(posedge clk) begin
      if (rst || start) begin
         ra <= NO_REG;
         rb <= NO_REG;
      end else if (take && has_regs && idx == LEN_W'(1)) begin
         ra <= data[7:4];
         rb <= data[3:0];
      end
   end

   logic [LEN_W-1:0] base;
   assign base = LEN_W'(cpos);

   for (genvar k = 0; k < CONST_BYTES; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst || start) begin
            valc[8*k +: 8] <= 8'h00;
         end else if (take && cpos != CP_NONE && idx == base + LEN_W'(k)) begin
            valc[8*k +: 8] <= data;
         end
      end
   end

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
   import ifetch_pkg::*;
#(
   parameter int               ADDR_W   = 32,
   parameter int               WORD_W   = 32,
   parameter logic [ADDR_W-1:0] START_PC = '0,
   localparam int              CB       = WORD_W / 8,
   localparam int              LEN_W    = $clog2(CB + 3)
) (
   input  logic              clk,
   input  logic              rst,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_data,
   input  logic              mem_err,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [3:0]        icode,
   output logic [3:0]        ifun,
   output logic [3:0]        ra,
   output logic [3:0]        rb,
   output logic [WORD_W-1:0] valc,
   output logic [LEN_W-1:0]  ilen,
   output logic [ADDR_W-1:0] next_pc,
   output logic [1:0]        stat
);

   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a positive multiple of 8");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   typedef enum logic [1:0] {
      S_FETCH = 2'd0,
      S_HOLD  = 2'd1,
      S_STOP  = 2'd2
   } fsm_t;

   fsm_t              state;
   fstat_t            stat_q;
   logic [ADDR_W-1:0] pc;
   logic [LEN_W-1:0]  idx;
   logic [LEN_W-1:0]  len_q;
   logic              regs_q;
   cpos_t             cpos_q;
   logic [3:0]        icode_q;
   logic [3:0]        ifun_q;

   logic [LEN_W-1:0]  d_len;
   logic              d_regs;
   cpos_t             d_cpos;
   logic              d_legal;
   logic              d_halt;

   ifetch_len_decode #(
      .CONST_BYTES (CB),
      .LEN_W       (LEN_W)
   ) u_dec (
      .first_byte (mem_data),
      .len        (d_len),
      .has_regs   (d_regs),
      .cpos       (d_cpos),
      .legal      (d_legal),
      .is_halt    (d_halt)
   );

   logic fetching;
   logic first;
   logic good_byte;

   assign fetching  = (state == S_FETCH);
   assign first     = (idx == '0);
   assign good_byte = fetching && !mem_err;

   ifetch_gather #(
      .CONST_BYTES (CB),
      .LEN_W       (LEN_W)
   ) u_gather (
      .clk      (clk),
      .rst      (rst),
      .start    (good_byte && first),
      .take     (good_byte),
      .idx      (idx),
      .data     (mem_data),
      .has_regs (first ? d_regs : regs_q),
      .cpos     (first ? d_cpos : cpos_q),
      .ra       (ra),
      .rb       (rb),
      .valc     (valc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= S_FETCH;
         stat_q  <= ST_RUN;
         pc      <= START_PC;
         idx     <= '0;
         len_q   <= LEN_W'(1);
         regs_q  <= 1'b0;
         cpos_q  <= CP_NONE;
         icode_q <= 4'h0;
         ifun_q  <= 4'h0;
      end else begin
         unique case (state)
            S_FETCH: begin
               if (mem_err) begin
                  stat_q <= ST_ADDR;
                  state  <= S_STOP;
                  idx    <= '0;
               end else if (first) begin
                  icode_q <= mem_data[7:4];
                  ifun_q  <= mem_data[3:0];
                  len_q   <= d_len;
                  regs_q  <= d_regs;
                  cpos_q  <= d_cpos;
                  if (!d_legal) begin
                     stat_q <= ST_ILL;
                     state  <= S_STOP;
                  end else if (d_len == LEN_W'(1)) begin
                     if (d_halt) stat_q <= ST_HALT;
                     state <= S_HOLD;
                  end else begin
                     idx <= LEN_W'(1);
                  end
               end else if (idx == len_q - LEN_W'(1)) begin
                  idx   <= '0;
                  state <= S_HOLD;
               end else begin
                  idx <= idx + LEN_W'(1);
               end
            end
            S_HOLD: begin
               if (out_ready) begin
                  if (stat_q != ST_RUN) begin
                     state <= S_STOP;
                  end else begin
                     pc    <= pc + ADDR_W'(len_q);
                     state <= S_FETCH;
                  end
               end
            end
            default: state <= S_STOP;
         endcase
      end
   end

   assign mem_req   = fetching;
   assign mem_addr  = pc + ADDR_W'(idx);
   assign out_valid = (state == S_HOLD);
   assign icode     = icode_q;
   assign ifun      = ifun_q;
   assign ilen      = len_q;
   assign next_pc   = pc + ADDR_W'(len_q);
   assign stat      = stat_q;

   // R5
   npc_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && stat == 2'd0) |=> (mem_req && mem_addr == $past(next_pc)));

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && !mem_req && $stable(icode) && $stable(ifun)
         && $stable(ra) && $stable(rb) && $stable(valc) && $stable(next_pc)));

   // R2
   len_legal_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (ilen == LEN_W'(1) || ilen == LEN_W'(2) || ilen == LEN_W'(CB + 1)
         || ilen == LEN_W'(CB + 2)));

   // R7
   halt_stat_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && icode == 4'h0) |-> (stat == 2'd1));

   // R10
   stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (stat != 2'd0) |=> (stat == $past(stat)));

   // R8
   stop_no_read_chk: assert property (@(posedge clk) disable iff (rst)
      (stat != 2'd0) |-> !mem_req);

endmodule

// File: tb/sim_ifetch_unit.sv
`timescale 1ns/1ps
module sim_ifetch_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [7:0]  mem_data;
   logic        mem_err;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [3:0]  icode, ifun, ra, rb;
   logic [31:0] valc;
   logic [2:0]  ilen;
   logic [31:0] next_pc;
   logic [1:0]  stat;

   logic [7:0]  mem [64];
   logic [31:0] err_limit = 32'd64;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   assign mem_data = (mem_addr < 32'd64) ? mem[mem_addr[5:0]] : 8'h00;
   assign mem_err  = (mem_addr >= err_limit);

   ifetch_unit u0 (
      .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_err(mem_err), .out_valid(out_valid),
      .out_ready(out_ready), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
      .valc(valc), .ilen(ilen), .next_pc(next_pc), .stat(stat)
   );

   // each entry: icode, ifun, ra, rb, constant (expected fields)
   localparam int NT = 13;
   localparam logic [47:0] TBL [NT] = '{
      {4'h1, 4'h0, 4'hF, 4'hF, 32'h0000_0000},
      {4'h2, 4'h0, 4'h0, 4'h1, 32'h0000_0000},
      {4'h2, 4'h6, 4'h3, 4'h4, 32'h0000_0000},
      {4'h3, 4'h0, 4'hF, 4'h3, 32'h1234_5678},
      {4'h4, 4'h0, 4'h1, 4'h5, 32'h0000_0018},
      {4'h5, 4'h0, 4'h6, 4'h7, 32'hFFFF_FFFC},
      {4'h6, 4'h3, 4'h0, 4'h0, 32'h0000_0000},
      {4'h7, 4'h0, 4'hF, 4'hF, 32'h0000_0100},
      {4'h7, 4'h6, 4'hF, 4'hF, 32'hDEAD_BEEF},
      {4'h8, 4'h0, 4'hF, 4'hF, 32'h0000_0040},
      {4'h9, 4'h0, 4'hF, 4'hF, 32'h0000_0000},
      {4'hA, 4'h0, 4'h5, 4'hF, 32'h0000_0000},
      {4'hB, 4'h0, 4'h4, 4'hF, 32'h0000_0000}
   };

   function automatic int exp_len(input logic [3:0] c);
      case (c)
         4'h0, 4'h1, 4'h9:        return 1;
         4'h2, 4'h6, 4'hA, 4'hB:  return 2;
         4'h7, 4'h8:              return 5;
         default:                 return 6;
      endcase
   endfunction

   function automatic bit exp_regs(input logic [3:0] c);
      return (c == 4'h2 || c == 4'h3 || c == 4'h4 || c == 4'h5 || c == 4'h6
              || c == 4'hA || c == 4'hB);
   endfunction

   function automatic int exp_coff(input logic [3:0] c);
      if (c == 4'h7 || c == 4'h8) return 1;
      if (c == 4'h3 || c == 4'h4 || c == 4'h5) return 2;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      out_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // waits for out_valid, counting reads; returns read count and first address
   task automatic wait_valid(output int nreads, output logic [31:0] first_a,
                             output bit timed_out);
      nreads = 0;
      first_a = 32'hX;
      timed_out = 1'b0;
      for (int w = 0; w < 40; w++) begin
         if (out_valid) return;
         if (mem_req) begin
            if (nreads == 0) first_a = mem_addr;
            if (nreads > 0 && mem_addr != first_a + 32'(nreads))
               chk(1'b0, "R2 consecutive", mem_addr, first_a + 32'(nreads));
            nreads++;
         end
         @(negedge clk);
      end
      timed_out = 1'b1;
   endtask

   task automatic accept();
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   int          p;
   int          nr;
   logic [31:0] fa;
   bit          to;
   logic [31:0] start_a;
   bit          saw_valid;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      // build program from the table
      p = 0;
      for (int i = 0; i < NT; i++) begin
         logic [3:0] c;
         c = TBL[i][47:44];
         mem[p] = TBL[i][47:40];
         if (exp_regs(c)) mem[p + 1] = TBL[i][39:32];
         if (exp_coff(c) != 0)
            for (int b = 0; b < 4; b++) mem[p + exp_coff(c) + b] = TBL[i][8*b +: 8];
         p += exp_len(c);
      end
      mem[p] = 8'h00;

      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(out_valid == 1'b0 && stat == 2'd0, "R1 in reset", {30'd0, stat}, 32'd0);
      rst = 1'b0;
      // R1 first cycle after reset
      chk(out_valid == 1'b0 && stat == 2'd0 && mem_req && mem_addr == 32'd0,
          "R1 after reset", mem_addr, 32'd0);

      start_a = 32'd0;
      for (int i = 0; i < NT; i++) begin
         logic [3:0] c;
         c = TBL[i][47:44];
         wait_valid(nr, fa, to);
         chk(!to, "R2 timeout", 32'(i), 32'd0);
         chk(nr == exp_len(c) && fa == start_a, "R2 read count", 32'(nr), 32'(exp_len(c)));
         chk(icode == c && ifun == TBL[i][43:40], "R3 opcode byte",
             {24'd0, icode, ifun}, {24'd0, TBL[i][47:40]});
         chk(ra == TBL[i][39:36] && rb == TBL[i][35:32], "R3 register byte",
             {24'd0, ra, rb}, {24'd0, TBL[i][39:32]});
         chk(valc == TBL[i][31:0], "R4 constant", valc, TBL[i][31:0]);
         chk(32'(ilen) == 32'(exp_len(c)) && next_pc == start_a + 32'(exp_len(c)),
             "R5 next pc", next_pc, start_a + 32'(exp_len(c)));
         chk(stat == 2'd0, "R7 running status", {30'd0, stat}, 32'd0);
         if (i == 3) begin
            for (int h = 0; h < 3; h++) begin
               @(negedge clk);
               chk(out_valid && !mem_req && valc == 32'h1234_5678 && rb == 4'h3,
                   "R6 hold under backpressure", valc, 32'h1234_5678);
            end
         end
         start_a = start_a + 32'(exp_len(c));
         accept();
         // R5 next read is at next_pc
         chk(mem_req && mem_addr == start_a, "R5 follow address", mem_addr, start_a);
      end

      // R7 halt
      wait_valid(nr, fa, to);
      chk(!to && out_valid && icode == 4'h0 && stat == 2'd1 && nr == 1,
          "R7 halt presented", {30'd0, stat}, 32'd1);
      accept();
      repeat (3) @(negedge clk);
      chk(!mem_req && !out_valid && stat == 2'd1, "R7 halted no reads",
          {31'd0, mem_req}, 32'd0);

      // R8 illegal first bytes
      begin
         logic [7:0] badb [5] = '{8'hC0, 8'h64, 8'h77, 8'h11, 8'h27};
         for (int k = 0; k < 5; k++) begin
            mem[0] = badb[k];
            do_reset();
            @(negedge clk);
            chk(stat == 2'd3 && !out_valid && !mem_req, "R8 illegal byte",
                {30'd0, stat}, 32'd3);
            repeat (3) @(negedge clk);
            // R10 sticky
            chk(stat == 2'd3 && !out_valid && !mem_req, "R10 status sticky",
                {30'd0, stat}, 32'd3);
         end
      end

      // R9 address error partway through a 6-byte instruction
      mem[0] = 8'h30; mem[1] = 8'hF2; mem[2] = 8'h11; mem[3] = 8'h22;
      mem[4] = 8'h33; mem[5] = 8'h44;
      err_limit = 32'd3;
      do_reset();
      saw_valid = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (out_valid) saw_valid = 1'b1;
         @(negedge clk);
      end
      chk(stat == 2'd2 && !saw_valid && !mem_req, "R9 error mid constant",
          {30'd0, stat}, 32'd2);

      // R9 address error on the opcode byte
      err_limit = 32'd0;
      do_reset();
      @(negedge clk);
      chk(stat == 2'd2 && !out_valid && !mem_req, "R9 error first byte",
          {30'd0, stat}, 32'd2);

      // R10 reset clears a stopped unit
      err_limit = 32'd64;
      mem[0] = 8'h10;
      do_reset();
      chk(stat == 2'd0 && !out_valid && mem_req && mem_addr == 32'd0, "R10 reset clears",
          {30'd0, stat}, 32'd0);
      wait_valid(nr, fa, to);
      chk(!to && icode == 4'h1 && next_pc == 32'd1, "R10 runs after reset", next_pc, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule